// File: doc/BRIEF.md
# Half-Bridge Dead-Time Interlock Controller

This block is the synchronous gate-enable logic for a single half-bridge leg. It receives two commands: a low-side command that is active low and a high-side command that is active high. Because of these opposite polarities, one wire can drive both command pins. A logic 0 on that wire then requests the low switch, and a logic 1 requests the high switch. The block returns one enable for each gate and one enable for the bootstrap charging switch.

Both commands and two under-voltage flags pass through a synchronizer before they are decoded. A request for both switches at once turns both gates off. No side gets priority. A switch may turn on only after a fixed number of clock cycles has passed since the opposite switch turned off. A request that arrives after that interval has already passed goes through with only the synchronizer latency. A supply under-voltage flag forces both gates off. A bootstrap under-voltage flag forces only the high gate off. Every recovery from a flag goes through a fresh dead-time interval. Reset also starts a full dead-time interval.

All latencies below are counted in clock edges from a change at the inputs. A change needs SYNC_STAGES edges to pass the synchronizer and one more edge to reach the gate register, so L = SYNC_STAGES + 1.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: While reset (rst_n = 0) is held, lo_gate, hi_gate and boot_chg_en are all 0.
- R2: The command pair decodes as follows. lo_cmd_n = 0 with hi_cmd = 0 requests the low gate. lo_cmd_n = 1 with hi_cmd = 1 requests the high gate. lo_cmd_n = 1 with hi_cmd = 0 requests neither gate. A gate whose request is withdrawn turns off exactly L edges after the input change.
- R3: lo_cmd_n = 0 together with hi_cmd = 1 is the overlap case. It turns both gates off L edges after it is applied, and keeps them off for as long as it lasts.
- R4: lo_gate and hi_gate are never 1 in the same cycle.
- R5: After one gate falls, the opposite gate stays off for DEAD_CYC cycles. If the opposite gate is requested within that window, it rises exactly DEAD_CYC edges after the fall. This also holds when one wire drives both commands.
- R6: If the opposite gate is requested after the dead time has already passed, it rises exactly L edges after its request is applied.
- R7: boot_chg_en equals lo_gate in every cycle.
- R8: supply_uv = 1 forces both gates off L edges after it is applied. Once the flag clears, a pending request is honoured exactly SYNC_STAGES + DEAD_CYC edges after the clear.
- R9: boot_uv = 1 forces hi_gate off L edges after it is applied. It has no effect on lo_gate, so a low request that arrives while the flag is set still rises L edges after it is applied.
- R10: After reset is released with a low request present, lo_gate rises exactly DEAD_CYC edges after the release, provided DEAD_CYC ≥ L.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lo_cmd_n | input | 1 | Low-side command, active low, asynchronous |
| hi_cmd | input | 1 | High-side command, active high, asynchronous |
| supply_uv | input | 1 | Supply under-voltage flag, asynchronous |
| boot_uv | input | 1 | Bootstrap under-voltage flag, asynchronous |
| lo_gate | output | 1 | Low switch gate enable |
| hi_gate | output | 1 | High switch gate enable |
| boot_chg_en | output | 1 | Bootstrap charging switch enable |

## Verification
The bench builds the block with DEAD_CYC = 6 and SYNC_STAGES = 2, which gives L = 3. With a dead time this short, every turn-on edge can be counted to the exact cycle. The bench also places a command both inside and outside the dead-time window, in runs of a few dozen cycles. Because DEAD_CYC is larger than L, a request that arrives just after a fall is still waiting when the window closes. This separates the held-off case from the direct-follow case.

// File: rtl/hb_pkg.sv
// Shared types for the half-bridge interlock controller.
// Assumes the command pair is already synchronous when it is decoded.
package hb_pkg;

    // Decoded meaning of the two command pins.
    typedef enum logic [1:0] {
        CMD_OFF     = 2'd0,
        CMD_LOW     = 2'd1,
        CMD_HIGH    = 2'd2,
        CMD_OVERLAP = 2'd3
    } hb_cmd_e;

    // Map {lo_cmd_n, hi_cmd} onto the decoded request.
    function automatic hb_cmd_e decode_cmd(input logic lo_n, input logic hi);
        case ({lo_n, hi})
            2'b00:   return CMD_LOW;
            2'b11:   return CMD_HIGH;
            2'b01:   return CMD_OVERLAP;
            default: return CMD_OFF;
        endcase
    endfunction

endpackage

// File: rtl/hb_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Every bit gets STAGES flip-flops. Reset loads RST_VAL, which must be the
// safe (nothing requested) level of each bit.
module hb_sync #(
    parameter int             W       = 4,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg [STAGES];

    // First stage captures the raw asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= din;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // Each further stage resolves metastability from the one before it.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/hb_cmd_decode.sv
// Turns the synchronized commands and flags into per-side turn-on wishes.
// Assumes the inputs are synchronous. Overlap yields no wish on either side.
module hb_cmd_decode
    import hb_pkg::*;
(
    input  logic    lo_n_s,
    input  logic    hi_s,
    input  logic    sup_uv_s,
    input  logic    boot_uv_s,
    output hb_cmd_e cmd_state,
    output logic    want_lo,
    output logic    want_hi
);

    // Decode the pin pair, then mask it with the under-voltage flags.
    always_comb begin
        cmd_state = decode_cmd(lo_n_s, hi_s);
        want_lo   = (cmd_state == CMD_LOW)  && !sup_uv_s;
        want_hi   = (cmd_state == CMD_HIGH) && !sup_uv_s && !boot_uv_s;
    end

endmodule

// File: rtl/hb_dt_timer.sv
// Dead-time down-counter for one side of the leg.
// A restart (or reset) loads DEAD_CYC-1. The counter then counts down to 0,
// where expired goes high. A gate sampled with expired = 1 therefore rises
// DEAD_CYC edges after the restart edge. Assumes DEAD_CYC >= 1.
module hb_dt_timer #(
    parameter int DEAD_CYC = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expired
);

    localparam int               CNT_W = $clog2(DEAD_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD  = CNT_W'(DEAD_CYC - 1);

    logic [CNT_W-1:0] cnt;

    // Reload on reset or restart, otherwise count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= LOAD;
        else if (restart)     cnt <= LOAD;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LOAD);                                          // R5
    AST_RESTART_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !expired || (LOAD == '0));                 // R5

endmodule

// File: rtl/hb_deadtime_ctrl.sv
// Top level: the gate-enable controller for one half-bridge leg.
// It synchronizes the commands and flags, decodes them, interlocks the two
// gates and delays every turn-on until the opposite gate has been off for
// DEAD_CYC cycles. Assumes the clock period times DEAD_CYC gives the
// required dead time.
module hb_deadtime_ctrl
    import hb_pkg::*;
#(
    parameter int DEAD_CYC    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lo_cmd_n,
    input  logic hi_cmd,
    input  logic supply_uv,
    input  logic boot_uv,
    output logic lo_gate,
    output logic hi_gate,
    output logic boot_chg_en
);

    localparam int NSIG  = 4;
    localparam int GAP_W = $clog2(DEAD_CYC + 1);
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(DEAD_CYC);
    // Safe reset levels, bit order {boot_uv, supply_uv, hi_cmd, lo_cmd_n}.
    localparam logic [NSIG-1:0] SYNC_RST = 4'b0001;

    logic [NSIG-1:0] raw_in, sync_out;
    logic            lo_n_s, hi_s, sup_uv_s, boot_uv_s;
    hb_cmd_e         cmd_state;
    logic            want_lo, want_hi;
    logic            lo_gate_q, hi_gate_q, boot_q;
    logic            lo_nxt, hi_nxt;
    logic [1:0]      restart, expired;   // index 0: low side, 1: high side

    assign raw_in = {boot_uv, supply_uv, hi_cmd, lo_cmd_n};

    hb_sync #(
        .W       (NSIG),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_in),
        .dout  (sync_out)
    );

    assign {boot_uv_s, sup_uv_s, hi_s, lo_n_s} = sync_out;

    hb_cmd_decode u_dec (
        .lo_n_s    (lo_n_s),
        .hi_s      (hi_s),
        .sup_uv_s  (sup_uv_s),
        .boot_uv_s (boot_uv_s),
        .cmd_state (cmd_state),
        .want_lo   (want_lo),
        .want_hi   (want_hi)
    );

    // Next gate values: a wish, an expired timer and an opposite gate that is off.
    always_comb begin
        lo_nxt = want_lo && expired[0] && !hi_gate_q;
        hi_nxt = want_hi && expired[1] && !lo_gate_q;
    end

    // Restart a side's timer when the opposite gate falls or a flag blocks that side.
    always_comb begin
        restart[0] = (hi_gate_q && !hi_nxt) || sup_uv_s;
        restart[1] = (lo_gate_q && !lo_nxt) || sup_uv_s || boot_uv_s;
    end

    genvar s;
    generate
        for (s = 0; s < 2; s++) begin : g_side
            hb_dt_timer #(
                .DEAD_CYC (DEAD_CYC)
            ) u_timer (
                .clk     (clk),
                .rst_n   (rst_n),
                .restart (restart[s]),
                .expired (expired[s])
            );
        end
    endgenerate

    // Gate registers. The bootstrap enable is a separate copy of the low gate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_gate_q <= 1'b0;
            hi_gate_q <= 1'b0;
            boot_q    <= 1'b0;
        end else begin
            lo_gate_q <= lo_nxt;
            hi_gate_q <= hi_nxt;
            boot_q    <= lo_nxt;
        end
    end

    assign lo_gate     = lo_gate_q;
    assign hi_gate     = hi_gate_q;
    assign boot_chg_en = boot_q;

    // Assertion support only: cycles since each opposite gate was last on, saturating.
    logic [GAP_W-1:0] lo_gap, hi_gap;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_gap <= '0;
            hi_gap <= '0;
        end else begin
            lo_gap <= hi_gate_q ? '0 : ((lo_gap == GAP_MAX) ? lo_gap : lo_gap + 1'b1);
            hi_gap <= lo_gate_q ? '0 : ((hi_gap == GAP_MAX) ? hi_gap : hi_gap + 1'b1);
        end
    end

    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !(lo_gate_q && hi_gate_q));                                       // R4
    AST_LO_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_gate_q) |-> (lo_gap >= GAP_MAX));                        // R5
    AST_HI_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_gate_q) |-> (hi_gap >= GAP_MAX));                        // R5
    AST_OVERLAP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_state == CMD_OVERLAP) |=> (!lo_gate_q && !hi_gate_q));       // R3
    AST_BOOT_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        boot_q == lo_gate_q);                                             // R7
    AST_SUPPLY_UV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        sup_uv_s |=> (!lo_gate_q && !hi_gate_q));                         // R8
    AST_BOOT_UV_HI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        boot_uv_s |=> !hi_gate_q);                                        // R9

endmodule

// File: tb/hb_deadtime_ctrl_tb.sv
// Directed bench for hb_deadtime_ctrl. Each scenario task checks its own results.
module hb_deadtime_ctrl_tb;

    localparam int DEAD = 6;
    localparam int SYNC = 2;
    localparam int LAT  = SYNC + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lo_cmd_n = 1'b0, hi_cmd = 1'b0, supply_uv = 1'b0, boot_uv = 1'b0;
    logic lo_gate, hi_gate, boot_chg_en;

    int n_checks = 0;
    int n_fail   = 0;
    int mirror_err = 0;
    int excl_err   = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hb_deadtime_ctrl #(.DEAD_CYC(DEAD), .SYNC_STAGES(SYNC)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .lo_cmd_n    (lo_cmd_n),
        .hi_cmd      (hi_cmd),
        .supply_uv   (supply_uv),
        .boot_uv     (boot_uv),
        .lo_gate     (lo_gate),
        .hi_gate     (hi_gate),
        .boot_chg_en (boot_chg_en)
    );

    // Background monitor at each falling edge: exclusivity and the bootstrap mirror.
    always @(negedge clk) begin
        if (rst_n) begin
            if (lo_gate && hi_gate)     excl_err++;
            if (boot_chg_en != lo_gate) mirror_err++;
        end
    end

    task automatic check_int(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Count rising clock edges until the chosen gate reaches val (-1 on timeout).
    task automatic edges_until(input bit pick_hi, input logic val, output int n);
        n = -1;
        for (int k = 1; k <= 100; k++) begin
            @(posedge clk);
            @(negedge clk);
            if ((pick_hi ? hi_gate : lo_gate) == val) begin
                n = k;
                break;
            end
        end
    endtask

    // Hold for cyc cycles and count the cycles where the gates differ from the expected values.
    task automatic hold_check(input int cyc, input logic elo, input logic ehi, input string tag);
        int bad = 0;
        for (int k = 0; k < cyc; k++) begin
            @(negedge clk);
            if (lo_gate != elo || hi_gate != ehi) bad++;
        end
        check_int(tag, bad, 0);
    endtask

    task automatic drive(input logic ln, input logic h);
        lo_cmd_n = ln;
        hi_cmd   = h;
    endtask

    task automatic t_reset();
        int n;
        drive(1'b0, 1'b0);
        repeat (4) @(negedge clk);
        check_int("R1 gates in reset", {lo_gate, hi_gate, boot_chg_en}, 0);
        rst_n = 1'b1;
        edges_until(1'b0, 1'b1, n);
        check_int("R10 first low turn-on after reset", n, DEAD);
        check_int("R7 boot enable with low gate", boot_chg_en, 1);
    endtask

    task automatic t_tied_wire();
        int n;
        drive(1'b1, 1'b1);
        edges_until(1'b0, 1'b0, n);
        check_int("R2 low off on high request", n, LAT);
        edges_until(1'b1, 1'b1, n);
        check_int("R5 high after dead time (tied)", n, DEAD);
        drive(1'b0, 1'b0);
        edges_until(1'b1, 1'b0, n);
        check_int("R2 high off on low request", n, LAT);
        edges_until(1'b0, 1'b1, n);
        check_int("R5 low after dead time (tied)", n, DEAD);
    endtask

    task automatic t_late_cmd();
        int n;
        drive(1'b1, 1'b0);
        edges_until(1'b0, 1'b0, n);
        check_int("R2 idle request turns low off", n, LAT);
        hold_check(2 * DEAD + 5, 1'b0, 1'b0, "R2 idle keeps both off");
        drive(1'b1, 1'b1);
        edges_until(1'b1, 1'b1, n);
        check_int("R6 late high follows directly", n, LAT);
    endtask

    task automatic t_inside_window();
        int n;
        drive(1'b1, 1'b0);
        edges_until(1'b1, 1'b0, n);
        check_int("R2 high off", n, LAT);
        drive(1'b0, 1'b0);
        edges_until(1'b0, 1'b1, n);
        check_int("R5 low held until dead time ends", n, DEAD);
    endtask

    task automatic t_overlap();
        int n;
        drive(1'b0, 1'b1);
        edges_until(1'b0, 1'b0, n);
        check_int("R3 overlap turns low off", n, LAT);
        hold_check(2 * DEAD + 5, 1'b0, 1'b0, "R3 overlap keeps both off");
        drive(1'b1, 1'b1);
        edges_until(1'b1, 1'b1, n);
        check_int("R6 high after overlap ends", n, LAT);
    endtask

    task automatic t_supply_uv();
        int n;
        supply_uv = 1'b1;
        edges_until(1'b1, 1'b0, n);
        check_int("R8 supply flag turns high off", n, LAT);
        drive(1'b0, 1'b0);
        hold_check(2 * DEAD + 5, 1'b0, 1'b0, "R8 supply flag keeps both off");
        supply_uv = 1'b0;
        edges_until(1'b0, 1'b1, n);
        check_int("R8 resume after fresh dead time", n, SYNC + DEAD);
    endtask

    task automatic t_boot_uv();
        int n;
        boot_uv = 1'b1;
        drive(1'b1, 1'b1);
        edges_until(1'b0, 1'b0, n);
        check_int("R9 low off on high request", n, LAT);
        hold_check(2 * DEAD + 5, 1'b0, 1'b0, "R9 boot flag blocks high");
        drive(1'b0, 1'b0);
        edges_until(1'b0, 1'b1, n);
        check_int("R9 low unaffected by boot flag", n, LAT);
        check_int("R7 boot enable follows low", boot_chg_en, 1);
        boot_uv = 1'b0;
        drive(1'b1, 1'b1);
        edges_until(1'b1, 1'b1, n);
        check_int("R5 high after flag clear and dead time", n, LAT + DEAD);
    endtask

    initial begin
        t_reset();
        t_tied_wire();
        t_late_cmd();
        t_inside_window();
        t_overlap();
        t_supply_uv();
        t_boot_uv();
        repeat (3) @(negedge clk);
        check_int("R4 gates never both on", excl_err, 0);
        check_int("R7 boot enable mirrors low gate", mirror_err, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: counts an expired run as a failed check and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule